// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. It runs the sixteen-state test state machine from the test clock and mode-select input. It holds a 3-bit instruction register, a one-bit bypass register and a 32-bit identification register. It drives the serial test output together with a separate output enable. The pad ring turns that enable into high impedance.

The boundary cells live outside this block. They appear here as a single serial return line plus a select and capture, shift and update strobes, all timed by the controller. A drive flag tells the cells when their update latches own the pins. Two more outputs command the system pins: one to float them and one to hold them at the preset boundary values.

An asynchronous active-low reset, or five test clocks with mode-select high, returns the controller to the reset state. The identification instruction becomes the active instruction in both cases, and the system logic runs normally.

Top module: `jtag_tap`

## Requirements
- R1: The state register moves only on the rising edge of `tck`, following the standard sixteen-state graph driven by the level of `tms`.
- R2: `trst_n` low at any time forces the reset state at once, loads the identification instruction, and drops `hiz_ctl`, `clamp_ctl`, `bsr_drive` and `tdo_oe`.
- R3: Five consecutive rising `tck` edges with `tms` high reach the reset state from any state and reload the identification instruction; four edges are not enough from Shift-DR.
- R4: The instruction register is 3 bits and is shifted LSB first. Its codes are 000 external test, 010 float pins, 011 clamp pins, 100 sample/preload, 110 identify and 111 bypass. Codes 001 and 101 act as bypass. A new instruction takes effect on the falling edge in Update-IR.
- R5: Capture-IR loads the instruction shift stage with 001, so the first three bits read out are 1, 0, 0.
- R6: The bypass register is one bit. It captures 0 and delays `tdi` by one clock, and it is the selected data register for bypass, float, clamp and the unused codes.
- R7: Under the identify instruction, Capture-DR loads the `ID_VALUE` parameter with bit 0 forced to 1, and it is shifted out LSB first.
- R8: Under external test or sample/preload, `bsr_sel` is high, `bsr_tdo` is routed to `tdo`, and `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR.
- R9: `hiz_ctl` is high only under the float instruction, and `clamp_ctl` only under clamp. `bsr_drive` is high under external test and clamp.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR.
- R11: While the controller idles in Run-Test-Idle, the active instruction and the pin controls stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trst_n | input | 1 | Asynchronous active-low test reset |
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| bsr_tdo | input | 1 | Serial return from the external boundary chain |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_drive | output | 1 | Boundary update latches drive the pins |
| hiz_ctl | output | 1 | Float all system outputs |
| clamp_ctl | output | 1 | Hold system outputs at boundary values |

## Verification
Two actions can fall in the same test clock: a reset request and an instruction that is already active. Pressing `tms` high in the middle of Shift-DR under clamp makes the fifth edge's return to reset coincide with the removal of the clamp. The check is that `clamp_ctl` is still high after four edges and low after five. The same conflict is provoked asynchronously by pulsing `trst_n` between clock edges under the float instruction. `hiz_ctl` must fall before the next edge, and the next data scan must return the identification value.

// File: rtl/jtag_tap.sv
module jtag_tap #(
  parameter logic [31:0] ID_VALUE = 32'h4C7A_1E36
) (
  input  logic trst_n,
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  input  logic bsr_tdo,
  output logic bsr_sel,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_drive,
  output logic hiz_ctl,
  output logic clamp_ctl
);
  localparam int IR_W = 3;
  localparam int ID_W = 32;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b110;
  localparam logic [IR_W-1:0] IR_CAPT   = 3'b001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_st_e;

  tap_st_e st, nxt;
  logic [IR_W-1:0] ir, ir_sr;
  logic [ID_W-1:0] id_sr;
  logic byp, sel_id, dr_bit, so_bit;

  always_comb begin
    case (st)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nxt = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nxt = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= TLR;
    else         st <= nxt;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)          ir_sr <= '0;
    else if (st == CAP_IR) ir_sr <= IR_CAPT;
    else if (st == SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)          byp <= 1'b0;
    else if (st == CAP_DR) byp <= 1'b0;
    else if (st == SH_DR)  byp <= tdi;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                     id_sr <= '0;
    else if (st == CAP_DR && sel_id) id_sr <= ID_VALUE | 32'd1;
    else if (st == SH_DR && sel_id)  id_sr <= {tdi, id_sr[ID_W-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)           ir <= OP_IDCODE;
    else if (st == TLR)    ir <= OP_IDCODE;
    else if (st == UPD_IR) ir <= ir_sr;

  assign sel_id    = (ir == OP_IDCODE);
  assign bsr_sel   = (ir == OP_EXTEST) || (ir == OP_SAMPLE);
  assign bsr_drive = (ir == OP_EXTEST) || (ir == OP_CLAMP);
  assign hiz_ctl   = (ir == OP_HIGHZ);
  assign clamp_ctl = (ir == OP_CLAMP);

  assign bsr_capture = bsr_sel && (st == CAP_DR);
  assign bsr_shift   = bsr_sel && (st == SH_DR);
  assign bsr_update  = bsr_sel && (st == UPD_DR);

  assign dr_bit = sel_id ? id_sr[0] : (bsr_sel ? bsr_tdo : byp);
  assign so_bit = (st == SH_IR) ? ir_sr[0] : dr_bit;

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= so_bit;
      tdo_oe <= (st == SH_DR) || (st == SH_IR);
    end

  // R3
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5)) |-> st == TLR);

  // R5
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    st == CAP_IR |=> ir_sr == IR_CAPT);

  // R6
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    st == CAP_DR |=> byp == 1'b0);

  // R10
  oe_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == SH_DR || st == SH_IR));

  // R8
  bsr_shift_oe_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_shift |-> tdo_oe);

  // R11
  ir_hold_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == RTI && $past(st) == RTI) |-> $stable(ir));
endmodule

// File: tb/jtag_tap_tb.sv
module jtag_tap_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] ID_RAW = 32'h4C7A_1E36;
  localparam logic [31:0] ID_EXP = ID_RAW | 32'd1;
  localparam logic [7:0] CHAIN_CAP = 8'hA5;
  localparam int NB = 40;
  // fields: {code[2:0], kind[1:0] (0 bypass,1 id,2 chain), hiz, clamp, drive}
  localparam logic [7:0] VEC [8] = '{
    {3'b000, 2'd2, 3'b001}, {3'b010, 2'd0, 3'b100},
    {3'b011, 2'd0, 3'b011}, {3'b100, 2'd2, 3'b000},
    {3'b110, 2'd1, 3'b000}, {3'b111, 2'd0, 3'b000},
    {3'b001, 2'd0, 3'b000}, {3'b101, 2'd0, 3'b000}};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, bsr_tdo, bsr_sel, bsr_capture, bsr_shift, bsr_update;
  logic bsr_drive, hiz_ctl, clamp_ctl;
  logic [7:0] chain = '0, chain_upd = '0;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) tck = ~tck;

  jtag_tap #(.ID_VALUE(ID_RAW)) dut_i (
    .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_tdo(bsr_tdo), .bsr_sel(bsr_sel), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update), .bsr_drive(bsr_drive),
    .hiz_ctl(hiz_ctl), .clamp_ctl(clamp_ctl));

  always @(posedge tck) begin
    if (bsr_capture)    chain <= CHAIN_CAP;
    else if (bsr_shift) chain <= {tdi, chain[7:1]};
    if (bsr_update)     chain_upd <= chain;
  end
  assign bsr_tdo = chain[0];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      if (i < 2) cap[i+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [NB-1:0] din, output logic [NB-1:0] dout, output logic oe_ok);
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = tdo; oe_ok = tdo_oe;
    for (int i = 0; i < NB; i++) begin
      step(i == NB-1, din[i]);
      if (i < NB-1) begin dout[i+1] = tdo; oe_ok = oe_ok & tdo_oe; end
      else oe_ok = oe_ok & !tdo_oe;
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [NB-1:0] expect_dr(input logic [1:0] kind, input logic [NB-1:0] din);
    logic [NB-1:0] e;
    for (int i = 0; i < NB; i++) begin
      if (kind == 2'd1)      e[i] = (i < 32) ? ID_EXP[i] : din[i-32];
      else if (kind == 2'd2) e[i] = (i < 8) ? CHAIN_CAP[i] : din[i-8];
      else                   e[i] = (i == 0) ? 1'b0 : din[i-1];
    end
    return e;
  endfunction

  initial begin
    #(CLK_P * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NB-1:0] din, dout;
    logic [2:0] cap;
    logic oe_ok;
    @(negedge tck); #1;
    #(CLK_P*2);
    trst_n = 1'b1;
    // R2 reset state
    chk("R2 reset outputs", {60'd0, tdo_oe, hiz_ctl, clamp_ctl, bsr_drive}, 64'd0);
    step(0, 0);
    din = 40'h12_3456_789A;
    scan_dr(din, dout, oe_ok);
    // R7 identification after reset without IR load
    chk("R7 id after reset", dout, expect_dr(2'd1, din));
    // R10 tdo_oe only during shift
    chk("R10 oe during scan", oe_ok, 1'b1);
    chk("R10 oe idle", tdo_oe, 1'b0);
    load_ir(3'b111, cap);
    // R5 captured IR pattern
    chk("R5 ir capture", cap, 3'b001);

    // R1 R4 R6 R7 R8 R9 table walk
    for (int v = 0; v < 8; v++) begin
      logic [2:0] code;
      logic [1:0] kind;
      code = VEC[v][7:5]; kind = VEC[v][4:3];
      load_ir(code, cap);
      chk($sformatf("R9 controls code %b", code),
          {bsr_sel, hiz_ctl, clamp_ctl, bsr_drive}, {kind == 2'd2, VEC[v][2:0]});
      din = 40'h9E_3779_B97F ^ {5{8'(v * 37 + 11)}};
      scan_dr(din, dout, oe_ok);
      chk($sformatf("R4 R6 R7 R8 scan code %b", code), dout, expect_dr(kind, din));
      if (kind == 2'd2)
        chk($sformatf("R8 chain update code %b", code), chain_upd, din[NB-1:NB-8]);
    end

    // R11 idle keeps instruction
    load_ir(3'b010, cap);
    for (int i = 0; i < 10; i++) step(0, 0);
    chk("R11 idle hold", {hiz_ctl, tdo_oe}, 2'b10);

    // R10 tdo moves on falling edge
    load_ir(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R10 tdo before fall", tdo, 1'b0);
    @(negedge tck); #1;
    chk("R10 tdo after fall", tdo, 1'b1);
    step(1, 0); step(1, 0); step(0, 0);

    // R3 five tms-high edges from Shift-DR under clamp
    load_ir(3'b011, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    chk("R3 four edges keep clamp", clamp_ctl, 1'b1);
    step(1, 0);
    chk("R3 five edges release clamp", clamp_ctl, 1'b0);
    step(0, 0);
    din = 40'hFF_0000_FFFF;
    scan_dr(din, dout, oe_ok);
    chk("R3 id reloaded", dout, expect_dr(2'd1, din));

    // R2 asynchronous reset mid-cycle
    load_ir(3'b010, cap);
    #2 trst_n = 1'b0;
    #1;
    chk("R2 async hiz drop", hiz_ctl, 1'b0);
    #1 trst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    din = 40'h5A_A5C3_3C0F;
    scan_dr(din, dout, oe_ok);
    chk("R2 id after async reset", dout, expect_dr(2'd1, din));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule